// File: doc/BRIEF.md
# Sized Integer ALU with Condition Flags

This block is a 32-bit integer execution unit that performs one operation per request. The operation runs at byte, word or long size. A request carries a destination operand, a source operand, a size code, an opcode and the current flag vector. One clock later the block returns the 32-bit result and the updated flag vector.

The opcodes cover three groups. The first is binary add, subtract and negate, each with a variant that also consumes the extend flag. The second is bitwise logic together with move/test, clear, half swap and sign extension. The third is pointer-style add and subtract, which always work at full width and do not change the flags.

Byte and word results are spliced into the destination, so the upper bits of the destination come through unchanged. This lets the result be written straight back to a 32-bit register. A pipeline control stage decodes the opcode into a small set of strobes, and a datapath stage holds the adder, the logic unit, the merge and the flag rules.

Top module: `sizedAlu`

## Requirements
- R1: `rspValid` rises exactly one clock after a cycle with `reqValid` high and is low otherwise. While `rstN` is low, `rspValid`, `result` and `flagsOut` are all zero.
- R2: Opcode 0 computes dst+src. Opcode 1 computes dst+src+X.
- R3: Opcode 2 computes dst−src and opcode 3 computes dst−src−X. Opcode 4 computes 0−dst and opcode 5 computes 0−dst−X.
- R4: The flag vector is {X,N,Z,V,C} in bits 4..0. For opcodes 0–5, N is the top bit of the sized result and V is signed overflow at that size. C is the carry out for additions and the borrow for subtractions and negations, and X is set equal to C.
- R5: For opcodes 1, 3 and 5, a nonzero sized result clears Z and a zero result leaves Z at its incoming value. The other arithmetic opcodes set Z when the sized result is zero.
- R6: Size code 0 is byte, 1 is word, and 2 or 3 is long. For byte and word operations other than opcodes 12–15, `result` bits above the size equal the same bits of `dst`.
- R7: Opcodes 6, 7, 8 and 9 give dst AND src, dst OR src, dst XOR src and NOT dst. N and Z come from the sized result, V and C are cleared, and X is kept.
- R8: Opcode 10 passes src at the chosen size and sets flags as in R7. Opcode 11 writes a sized zero and gives N=0, Z=1, V=0 and C=0 with X kept.
- R9: Opcode 12 exchanges dst[31:16] with dst[15:0] regardless of size, with R7 flag rules at long size.
- R10: Opcode 13 at long size sign-extends dst[15:0] to 32 bits. At byte or word size it sign-extends dst[7:0] into the low 16 bits and keeps dst[31:16]. R7 flag rules apply at the target width.
- R11: Opcode 14 gives dst+src and opcode 15 gives dst−src, both over all 32 bits. At long size src is used whole; otherwise src[15:0] is sign-extended first. `flagsOut` equals `flagsIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe |
| opcode | input | 4 | Operation select |
| size | input | 2 | Operand size code |
| dst | input | 32 | Destination operand |
| src | input | 32 | Source operand |
| flagsIn | input | 5 | Current flags {X,N,Z,V,C} |
| rspValid | output | 1 | Result strobe, one clock after the request |
| result | output | 32 | Merged result |
| flagsOut | output | 5 | Updated flags {X,N,Z,V,C} |

## Verification
The assertions assume that `reqValid` is low for the whole reset and that inputs are stable around the rising edge. They compare each response only with the request of the previous cycle, so they also assume that every request is one cycle long and stands alone. The stimulus drives all inputs at the falling edge and keeps `reqValid` low during reset. It runs requests back to back or with idle gaps, and every size code, including the unused code 3, is legal input.

// File: rtl/sizedAluPkg.sv
package sizedAluPkg;
  localparam int LongW = 32;
  localparam int WordW = 16;
  localparam int ByteW = 8;
  localparam int FlagW = 5;
  localparam int OpW   = 4;
  localparam int SzW   = 2;

  localparam int FlgX = 4;
  localparam int FlgN = 3;
  localparam int FlgZ = 2;
  localparam int FlgV = 1;
  localparam int FlgC = 0;

  typedef enum logic [SzW-1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_ALT  = 2'd3
  } sizeT;

  typedef enum logic [OpW-1:0] {
    OP_ADD  = 4'd0,  OP_ADDX = 4'd1,  OP_SUB  = 4'd2,  OP_SUBX = 4'd3,
    OP_NEG  = 4'd4,  OP_NEGX = 4'd5,  OP_AND  = 4'd6,  OP_OR   = 4'd7,
    OP_XOR  = 4'd8,  OP_NOT  = 4'd9,  OP_MOVE = 4'd10, OP_CLR  = 4'd11,
    OP_SWAP = 4'd12, OP_EXT  = 4'd13, OP_ADDA = 4'd14, OP_SUBA = 4'd15
  } opT;

  typedef enum logic [2:0] {
    K_ARITH, K_LOGIC, K_MOVE, K_CLR, K_SWAP, K_EXT, K_ADDR
  } kindT;

  typedef enum logic [1:0] {L_AND, L_OR, L_XOR, L_NOT} logicT;

  typedef enum logic [1:0] {F_ARITH, F_LOGIC, F_KEEP} flagModeT;

  typedef struct packed {
    kindT     kind;
    logicT    logicOp;
    flagModeT flagMode;
    logic     invertB;   // subtract form
    logic     zeroA;     // negate form: first operand forced to zero
    logic     bFromDst;  // negate form: second operand is dst
    logic     useX;      // extend flag as carry/borrow in
    logic     stickyZ;   // Z only cleared, never set
  } ctrlT;

  function automatic logic [LongW-1:0] sizeMask(input logic [SzW-1:0] sz);
    case (sz)
      SZ_BYTE: sizeMask = LongW'((64'd1 << ByteW) - 64'd1);
      SZ_WORD: sizeMask = LongW'((64'd1 << WordW) - 64'd1);
      default: sizeMask = '1;
    endcase
  endfunction

  function automatic logic topBit(input logic [SzW-1:0] sz, input logic [LongW-1:0] v);
    case (sz)
      SZ_BYTE: topBit = v[ByteW-1];
      SZ_WORD: topBit = v[WordW-1];
      default: topBit = v[LongW-1];
    endcase
  endfunction

  function automatic logic carryBit(input logic [SzW-1:0] sz, input logic [LongW:0] v);
    case (sz)
      SZ_BYTE: carryBit = v[ByteW];
      SZ_WORD: carryBit = v[WordW];
      default: carryBit = v[LongW];
    endcase
  endfunction
endpackage

// File: rtl/sizedAluCtrl.sv
module sizedAluCtrl
  import sizedAluPkg::*;
(
  input  logic [OpW-1:0] opcode,
  output ctrlT           ctrl
);
  always_comb begin
    ctrl = '{kind: K_ARITH, logicOp: L_AND, flagMode: F_ARITH,
             invertB: 1'b0, zeroA: 1'b0, bFromDst: 1'b0,
             useX: 1'b0, stickyZ: 1'b0};
    unique case (opT'(opcode))
      OP_ADD:  ;
      OP_ADDX: begin ctrl.useX = 1'b1; ctrl.stickyZ = 1'b1; end
      OP_SUB:  ctrl.invertB = 1'b1;
      OP_SUBX: begin
        ctrl.invertB = 1'b1; ctrl.useX = 1'b1; ctrl.stickyZ = 1'b1;
      end
      OP_NEG:  begin
        ctrl.invertB = 1'b1; ctrl.zeroA = 1'b1; ctrl.bFromDst = 1'b1;
      end
      OP_NEGX: begin
        ctrl.invertB = 1'b1; ctrl.zeroA = 1'b1; ctrl.bFromDst = 1'b1;
        ctrl.useX = 1'b1; ctrl.stickyZ = 1'b1;
      end
      OP_AND:  begin ctrl.kind = K_LOGIC; ctrl.logicOp = L_AND; ctrl.flagMode = F_LOGIC; end
      OP_OR:   begin ctrl.kind = K_LOGIC; ctrl.logicOp = L_OR;  ctrl.flagMode = F_LOGIC; end
      OP_XOR:  begin ctrl.kind = K_LOGIC; ctrl.logicOp = L_XOR; ctrl.flagMode = F_LOGIC; end
      OP_NOT:  begin ctrl.kind = K_LOGIC; ctrl.logicOp = L_NOT; ctrl.flagMode = F_LOGIC; end
      OP_MOVE: begin ctrl.kind = K_MOVE; ctrl.flagMode = F_LOGIC; end
      OP_CLR:  begin ctrl.kind = K_CLR;  ctrl.flagMode = F_LOGIC; end
      OP_SWAP: begin ctrl.kind = K_SWAP; ctrl.flagMode = F_LOGIC; end
      OP_EXT:  begin ctrl.kind = K_EXT;  ctrl.flagMode = F_LOGIC; end
      OP_ADDA: begin ctrl.kind = K_ADDR; ctrl.flagMode = F_KEEP; end
      OP_SUBA: begin ctrl.kind = K_ADDR; ctrl.flagMode = F_KEEP; ctrl.invertB = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/sizedAluPath.sv
module sizedAluPath
  import sizedAluPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  ctrlT             ctrl,
  input  logic [SzW-1:0]   size,
  input  logic [LongW-1:0] dst,
  input  logic [LongW-1:0] src,
  input  logic [FlagW-1:0] flagsIn,
  output logic             rspValid,
  output logic [LongW-1:0] result,
  output logic [FlagW-1:0] flagsOut
);
  localparam int HalfW = LongW / 2;

  logic [SzW-1:0]   effSize;
  logic [LongW-1:0] mask;
  logic [LongW-1:0] opA, opB, aM, bM;
  logic             carryIn;
  logic [LongW:0]   sum;
  logic             carryOut, rTop, aTop, bTop;
  logic             arithC, arithV;
  logic [LongW-1:0] srcWide, addrRes;
  logic [LongW-1:0] logicRes, extRes, core, merged;
  logic             isZero;
  logic [FlagW-1:0] flagsNext;

  // Width the operation works at
  always_comb begin
    case (ctrl.kind)
      K_SWAP, K_ADDR: effSize = SZ_LONG;
      K_EXT:          effSize = (size == SZ_BYTE || size == SZ_WORD) ? SZ_WORD : SZ_LONG;
      default:        effSize = size;
    endcase
  end

  assign mask = sizeMask(effSize);

  // Sized adder: operands masked, subtract by inversion
  assign opA     = ctrl.zeroA ? '0 : dst;
  assign opB     = ctrl.bFromDst ? dst : src;
  assign aM      = opA & mask;
  assign bM      = (ctrl.invertB ? ~opB : opB) & mask;
  assign carryIn = ctrl.useX ? (ctrl.invertB ? ~flagsIn[FlgX] : flagsIn[FlgX])
                             : ctrl.invertB;
  assign sum     = {1'b0, aM} + {1'b0, bM} + {{LongW{1'b0}}, carryIn};

  assign carryOut = carryBit(effSize, sum);
  assign rTop     = topBit(effSize, sum[LongW-1:0]);
  assign aTop     = topBit(effSize, aM);
  assign bTop     = topBit(effSize, bM);
  assign arithC   = ctrl.invertB ? ~carryOut : carryOut;
  assign arithV   = (aTop == bTop) && (rTop != aTop);

  // Full-width pointer arithmetic
  assign srcWide = (size == SZ_BYTE || size == SZ_WORD)
                 ? {{HalfW{src[HalfW-1]}}, src[HalfW-1:0]} : src;
  assign addrRes = ctrl.invertB ? dst - srcWide : dst + srcWide;

  always_comb begin
    case (ctrl.logicOp)
      L_AND:   logicRes = dst & src;
      L_OR:    logicRes = dst | src;
      L_XOR:   logicRes = dst ^ src;
      default: logicRes = ~dst;
    endcase
  end

  assign extRes = (effSize == SZ_WORD)
                ? {dst[LongW-1:HalfW], {(HalfW-ByteW){dst[ByteW-1]}}, dst[ByteW-1:0]}
                : {{HalfW{dst[HalfW-1]}}, dst[HalfW-1:0]};

  always_comb begin
    case (ctrl.kind)
      K_ARITH: core = sum[LongW-1:0];
      K_LOGIC: core = logicRes;
      K_MOVE:  core = src;
      K_CLR:   core = '0;
      K_SWAP:  core = {dst[HalfW-1:0], dst[LongW-1:HalfW]};
      K_EXT:   core = extRes;
      default: core = addrRes;
    endcase
  end

  assign merged = (dst & ~mask) | (core & mask);
  assign isZero = ((core & mask) == '0);

  always_comb begin
    flagsNext = flagsIn;
    case (ctrl.flagMode)
      F_ARITH: begin
        flagsNext[FlgX] = arithC;
        flagsNext[FlgC] = arithC;
        flagsNext[FlgV] = arithV;
        flagsNext[FlgN] = rTop;
        flagsNext[FlgZ] = ctrl.stickyZ ? (flagsIn[FlgZ] & isZero) : isZero;
      end
      F_LOGIC: begin
        flagsNext[FlgN] = topBit(effSize, core);
        flagsNext[FlgZ] = isZero;
        flagsNext[FlgV] = 1'b0;
        flagsNext[FlgC] = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      result   <= '0;
      flagsOut <= '0;
    end else begin
      rspValid <= reqValid;
      if (reqValid) begin
        result   <= merged;
        flagsOut <= flagsNext;
      end
    end
  end
endmodule

// File: rtl/sizedAlu.sv
module sizedAlu
  import sizedAluPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [3:0]  opcode,
  input  logic [1:0]  size,
  input  logic [31:0] dst,
  input  logic [31:0] src,
  input  logic [4:0]  flagsIn,
  output logic        rspValid,
  output logic [31:0] result,
  output logic [4:0]  flagsOut
);
  ctrlT ctrl;

  sizedAluCtrl uCtrl (
    .opcode (opcode),
    .ctrl   (ctrl)
  );

  sizedAluPath uPath (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .ctrl     (ctrl),
    .size     (size),
    .dst      (dst),
    .src      (src),
    .flagsIn  (flagsIn),
    .rspValid (rspValid),
    .result   (result),
    .flagsOut (flagsOut)
  );
endmodule

// File: rtl/sizedAluChecker.sv
module sizedAluChecker (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic [3:0]  opcode,
  input logic [1:0]  size,
  input logic [31:0] dst,
  input logic [31:0] src,
  input logic [4:0]  flagsIn,
  input logic        rspValid,
  input logic [31:0] result,
  input logic [4:0]  flagsOut
);
  assert_resp_timing_R1: assert property (@(posedge clk) disable iff (!rstN)
    rspValid == $past(reqValid));

  assert_x_follows_c_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && opcode <= 4'd5) |=> (flagsOut[4] == flagsOut[0]));

  assert_sticky_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && opcode[0] && opcode <= 4'd5 && !flagsIn[2]) |=> !flagsOut[2]);

  assert_byte_merge_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && size == 2'd0 && opcode < 4'd12) |=> (result[31:8] == $past(dst[31:8])));

  assert_logic_flags_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && opcode >= 4'd6 && opcode <= 4'd13)
      |=> (flagsOut[1:0] == 2'b00 && flagsOut[4] == $past(flagsIn[4])));

  assert_clear_flags_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && opcode == 4'd11) |=> (flagsOut[3:0] == 4'b0100));

  assert_addr_flags_R11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && opcode >= 4'd14) |=> (flagsOut == $past(flagsIn)));
endmodule

bind sizedAlu sizedAluChecker uChecker (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .opcode(opcode), .size(size),
  .dst(dst), .src(src), .flagsIn(flagsIn), .rspValid(rspValid),
  .result(result), .flagsOut(flagsOut)
);

// File: tb/sizedAlu_test.sv
`timescale 1ns/1ps
module sizedAlu_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [3:0]  opcode = '0;
  logic [1:0]  size = '0;
  logic [31:0] dst = '0;
  logic [31:0] src = '0;
  logic [4:0]  flagsIn = '0;
  logic        rspValid;
  logic [31:0] result;
  logic [4:0]  flagsOut;

  int checks = 0;
  int fails = 0;
  int pushed = 0;
  int popped = 0;
  logic [36:0] expQ[$];
  string       tagQ[$];

  always #2 clk = ~clk;

  sizedAlu uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .opcode(opcode), .size(size),
    .dst(dst), .src(src), .flagsIn(flagsIn), .rspValid(rspValid),
    .result(result), .flagsOut(flagsOut)
  );

  function automatic longint sgn(input longint unsigned v, input int w);
    longint unsigned half = 64'd1 << (w - 1);
    if (v >= half) return longint'(v) - longint'(half << 1);
    return longint'(v);
  endfunction

  // Reference model written from the requirements; returns {flags, result}
  function automatic logic [36:0] refModel(input int op, input int sz,
      input logic [31:0] d, input logic [31:0] s, input logic [4:0] f);
    int w;
    longint unsigned m, a, b, r, full, cx;
    longint ex, lim;
    logic x, n, z, v, c;
    logic [31:0] res;
    w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    if (op == 12) w = 32;
    if (op == 13) w = (sz >= 2) ? 32 : 16;
    m = (64'd1 << w) - 1;
    lim = longint'(64'd1 << (w - 1));
    x = f[4]; n = f[3]; z = f[2]; v = f[1]; c = f[0];
    r = 0;
    res = d;
    if (op <= 5) begin
      cx = (op % 2 == 1) ? longint'(f[4]) : 0;
      a  = (op >= 4) ? 0 : (longint'(d) & m);
      b  = (op >= 4) ? (longint'(d) & m) : (longint'(s) & m);
      if (op <= 1) begin
        full = a + b + cx;
        r = full & m;
        c = (full > m);
        ex = sgn(a, w) + sgn(b, w) + longint'(cx);
      end else begin
        r = (a - b - cx) & m;
        c = (a < b + cx);
        ex = sgn(a, w) - sgn(b, w) - longint'(cx);
      end
      v = (ex >= lim) || (ex < -lim);
      x = c;
      n = r >= longint'(lim);
      z = (op % 2 == 1) ? (f[2] && r == 0) : (r == 0);
      res = (d & ~m[31:0]) | r[31:0];
    end else if (op <= 13) begin
      case (op)
        6:  r = longint'(d & s) & m;
        7:  r = longint'(d | s) & m;
        8:  r = longint'(d ^ s) & m;
        9:  r = longint'(~d) & m;
        10: r = longint'(s) & m;
        11: r = 0;
        12: r = longint'({d[15:0], d[31:16]});
        default: r = (w == 32) ? longint'({{16{d[15]}}, d[15:0]})
                               : longint'({{8{d[7]}}, d[7:0]});
      endcase
      n = r >= longint'(lim);
      z = (r == 0);
      v = 1'b0;
      c = 1'b0;
      res = (d & ~m[31:0]) | r[31:0];
    end else begin
      logic [31:0] sw;
      sw = (sz >= 2) ? s : {{16{s[15]}}, s[15:0]};
      res = (op == 14) ? d + sw : d - sw;
    end
    return {x, n, z, v, c, res};
  endfunction

  function automatic string tagFor(input int op);
    if (op <= 1) return "R2";
    if (op <= 5) return "R3";
    if (op <= 9) return "R7";
    if (op <= 11) return "R8";
    if (op == 12) return "R9";
    if (op == 13) return "R10";
    return "R11";
  endfunction

  task automatic check(input string tag, input bit ok, input logic [36:0] act,
                       input logic [36:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual result=%h flags=%b expected result=%h flags=%b",
               tag, act[31:0], act[36:32], exp[31:0], exp[36:32]);
    end
  endtask

  task automatic drive(input int op, input int sz, input logic [31:0] d,
                       input logic [31:0] s, input logic [4:0] f, input string tag);
    @(negedge clk);
    reqValid = 1'b1;
    opcode = 4'(op);
    size = 2'(sz);
    dst = d;
    src = s;
    flagsIn = f;
    expQ.push_back(refModel(op, sz, d, s, f));
    tagQ.push_back(tag);
    pushed++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reqValid = 1'b0;
    end
  endtask

  // Monitor: pops the scoreboard when a result appears
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (expQ.size() == 0) begin
        check("R1", 1'b0, {flagsOut, result}, '0);
      end else begin
        logic [36:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        popped++;
        check(t, {flagsOut, result} === e, {flagsOut, result}, e);
      end
    end
  end

  initial begin
    #150000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", rspValid == 1'b0 && result == '0 && flagsOut == '0,
          {flagsOut, result}, '0);
    rstN = 1'b1;
    idle(2);
    check("R1", rspValid == 1'b0, {flagsOut, result}, '0);

    drive(0, 0, 32'hAABBCC7F, 32'h00000001, 5'b00000, "R4");
    drive(0, 0, 32'h123456FF, 32'h00000001, 5'b00000, "R6");
    drive(0, 2, 32'hFFFFFFFF, 32'h00000001, 5'b00000, "R2");
    drive(1, 1, 32'h55550001, 32'h0000FFFE, 5'b10100, "R5");
    drive(1, 1, 32'h55550001, 32'h00000001, 5'b10100, "R5");
    drive(1, 0, 32'h000000FF, 32'h00000000, 5'b10000, "R5");
    drive(2, 1, 32'hCAFE0000, 32'h00000001, 5'b00000, "R4");
    drive(2, 2, 32'h80000000, 32'h00000001, 5'b00000, "R4");
    drive(3, 0, 32'h00000010, 32'h00000010, 5'b10100, "R5");
    drive(4, 0, 32'h11111180, 32'h0, 5'b00000, "R3");
    drive(4, 2, 32'h00000000, 32'h0, 5'b11111, "R3");
    drive(5, 2, 32'h00000000, 32'h0, 5'b10100, "R3");
    idle(2);
    check("R1", rspValid == 1'b0, {flagsOut, result}, '0);
    drive(6, 1, 32'hFFFF8F0F, 32'h0000F0FF, 5'b10011, "R7");
    drive(7, 0, 32'h12345600, 32'h00000000, 5'b10011, "R7");
    drive(8, 2, 32'hA5A5A5A5, 32'hA5A5A5A5, 5'b00011, "R7");
    drive(9, 1, 32'h9999FFFF, 32'h0, 5'b10011, "R7");
    drive(10, 1, 32'h12345678, 32'hFFFF8000, 5'b10011, "R8");
    drive(11, 0, 32'hDEADBEEF, 32'h0, 5'b11011, "R8");
    drive(12, 0, 32'h8000ABCD, 32'h0, 5'b10000, "R9");
    drive(13, 1, 32'h12345680, 32'h0, 5'b00000, "R10");
    drive(13, 0, 32'h1234567F, 32'h0, 5'b10000, "R10");
    drive(13, 2, 32'h00008000, 32'h0, 5'b00000, "R10");
    drive(14, 1, 32'h00001000, 32'h0000FFFF, 5'b10101, "R11");
    drive(15, 2, 32'h00000000, 32'h00000001, 5'b01010, "R11");
    drive(14, 0, 32'h7FFFFFFF, 32'hFFFF0001, 5'b00000, "R11");

    for (int i = 0; i < 120; i++) begin
      int op;
      op = int'($urandom_range(15, 0));
      drive(op, int'($urandom_range(3, 0)), $urandom, $urandom,
            5'($urandom_range(31, 0)), tagFor(op));
      if (i % 17 == 0) idle(1);
    end
    idle(4);
    check("R1", pushed == popped && expQ.size() == 0,
          37'(popped), 37'(pushed));
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule